// File: doc/BRIEF.md
# Single-Wire Pulse-Count Token Receiver

This block is the device end of a one-wire bus that rests high. It turns low pulses on the wire into Wake, Zero and One tokens. It also decides whether the device is asleep or awake. Every time value is a parameter in nanoseconds and is converted to system-clock cycles by the `CLK_MHZ` parameter.

While asleep, the receiver only looks for one long low level, which wakes it. After a wake it waits for a quiet high guard interval and then decodes tokens. A token always opens with a start pulse of bounded width. If one more low pulse follows inside the same bit window, the bit is 0; if none follows, the bit is 1. Bits are packed least significant first into words, and each finished word is presented with a one-cycle strobe. A malformed token raises a one-cycle framing error and throws away the partial word.

Two timers send the device back to sleep. A per-token timer starts at a token's first edge and fires if no valid token completes in time. A watchdog fires a fixed time after every wake, whatever the bus is doing.

Top module: `swi_token_rx`

## Requirements
- R1: After reset `awake_o`, `word_vld_o` and `frame_err_o` are 0.
- R2: While asleep, data tokens and low pulses shorter than `WAKE_LO_NS` cause no strobe, no framing error and no wake.
- R3: A filtered low level held for `WAKE_LO_NS` while asleep sets `awake_o` to 1.
- R4: After a wake, decoding starts only once the line has stayed high for `WAKE_HI_NS` without a break. A low pulse during this guard restarts the guard and is not decoded as a bit.
- R5: Each run of `WORD_W` decoded bits gives one word on `word_o`, with the first bit received in bit 0. `word_vld_o` is high for exactly one cycle per word.
- R6: A token's first falling edge opens a decision point `DECIDE_NS` later. One low pulse before that point is a 1. Two low pulses are a 0. Every low pulse must last `START_MIN_NS` to `START_MAX_NS`.
- R7: While awake, low or high pulses shorter than `GLITCH_NS` do not change the decoded bits.
- R8: Each of these raises `frame_err_o` for one cycle and discards the partial word: a low pulse shorter or longer than the allowed width, or a third low pulse before the decision point.
- R9: If no valid token completes within `TIMEOUT_NS` of the first edge of a pending token, `awake_o` returns to 0. With no pending token, no timeout runs.
- R10: `awake_o` returns to 0 `WDOG_NS` after each wake, regardless of bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw bus wire, idle high |
| awake_o | output | 1 | Device is in the active state |
| word_o | output | WORD_W | Last completed word, first bit in bit 0 |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| frame_err_o | output | 1 | One-cycle strobe for a malformed token |

## Verification
The assertions assume three things about the inputs. The raw wire is sampled by the system clock with no relation to its phase. Reset is held long enough to clear the synchronizer. A wake low lasts well beyond the filter and synchronizer delay, so the raw wire is still low a few cycles before the wake is flagged. The stimulus meets these by driving the wire only on falling clock edges and by holding every wake low 100 cycles past the threshold. Every intended token pulse is far longer than the filter, and the only sub-filter pulses are deliberate single-cycle glitches.

// File: rtl/swi_rx_pkg.sv
package swi_rx_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_GUARD,
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_ERR
  } rx_state_e;

  function automatic int ns2cyc(int ns, int mhz);
    longint t;
    t = (longint'(ns) * longint'(mhz)) / 1000;
    return int'(t);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swi_glitch_filter.sv
module swi_glitch_filter #(
  parameter int FILT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // q_o follows only after FILT_CYC consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      q_o    <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] != q_o) begin
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          q_o   <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/swi_word_shift.sv
module swi_word_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int CW = $clog2(WORD_W);

  logic [WORD_W-1:0] sreg_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] sreg_nx;

  assign sreg_nx = {bit_i, sreg_q[WORD_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q     <= '0;
      cnt_q      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (bit_vld_i) begin
        sreg_q <= sreg_nx;
        if (cnt_q == CW'(WORD_W - 1)) begin
          cnt_q      <= '0;
          word_o     <= sreg_nx;
          word_vld_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swi_token_rx.sv
module swi_token_rx
  import swi_rx_pkg::*;
#(
  parameter int CLK_MHZ      = 50,
  parameter int GLITCH_NS    = 45,
  parameter int START_MIN_NS = 4100,
  parameter int START_MAX_NS = 4560,
  parameter int DECIDE_NS    = 26000,
  parameter int WAKE_LO_NS   = 60000,
  parameter int WAKE_HI_NS   = 1000000,
  parameter int TIMEOUT_NS   = 10000000,
  parameter int WDOG_NS      = 500000000,
  parameter int WORD_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              awake_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              frame_err_o
);
  localparam int GL_CYC        = (GLITCH_NS * CLK_MHZ + 999) / 1000 + 1;
  localparam int FILT_CYC      = max2(2, GL_CYC);
  localparam int START_MIN_CYC = ns2cyc(START_MIN_NS, CLK_MHZ);
  localparam int START_MAX_CYC = ns2cyc(START_MAX_NS, CLK_MHZ);
  localparam int DECIDE_CYC    = ns2cyc(DECIDE_NS, CLK_MHZ);
  localparam int WAKE_LO_CYC   = ns2cyc(WAKE_LO_NS, CLK_MHZ);
  localparam int WAKE_HI_CYC   = ns2cyc(WAKE_HI_NS, CLK_MHZ);
  localparam int TIMEOUT_CYC   = ns2cyc(TIMEOUT_NS, CLK_MHZ);
  localparam int WDOG_CYC      = ns2cyc(WDOG_NS, CLK_MHZ);

  localparam int PW_W  = $clog2(max2(max2(WAKE_LO_CYC, WAKE_HI_CYC), START_MAX_CYC) + 2);
  localparam int TOK_W = $clog2(DECIDE_CYC + 2);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int WD_W  = $clog2(WDOG_CYC + 1);

  localparam logic [PW_W-1:0]  START_MIN_C = PW_W'(START_MIN_CYC);
  localparam logic [PW_W-1:0]  START_MAX_C = PW_W'(START_MAX_CYC);
  localparam logic [PW_W-1:0]  WAKE_LO_C   = PW_W'(WAKE_LO_CYC - 1);
  localparam logic [PW_W-1:0]  WAKE_HI_C   = PW_W'(WAKE_HI_CYC - 1);
  localparam logic [TOK_W-1:0] DECIDE_C    = TOK_W'(DECIDE_CYC - 1);
  localparam logic [TO_W-1:0]  TIMEOUT_C   = TO_W'(TIMEOUT_CYC - 1);
  localparam logic [WD_W-1:0]  WDOG_C      = WD_W'(WDOG_CYC - 1);

  rx_state_e        state_q;
  logic             line_f;
  logic [PW_W-1:0]  pw_q;
  logic [TOK_W-1:0] tok_q;
  logic [TO_W-1:0]  to_q;
  logic [WD_W-1:0]  wd_q;
  logic             to_arm_q;
  logic             second_q;
  logic             bit_vld_q;
  logic             bit_val_q;
  logic             err_q;
  logic             force_sleep;

  swi_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_f)
  );

  assign force_sleep = awake_o && ((to_arm_q && to_q == TIMEOUT_C) || wd_q == WDOG_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SLEEP;
      awake_o   <= 1'b0;
      pw_q      <= '0;
      tok_q     <= '0;
      to_q      <= '0;
      wd_q      <= '0;
      to_arm_q  <= 1'b0;
      second_q  <= 1'b0;
      bit_vld_q <= 1'b0;
      bit_val_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      bit_vld_q <= 1'b0;
      err_q     <= 1'b0;
      if (awake_o) wd_q <= wd_q + 1'b1;
      if (to_arm_q) to_q <= to_q + 1'b1;
      if (force_sleep) begin
        state_q  <= ST_SLEEP;
        awake_o  <= 1'b0;
        to_arm_q <= 1'b0;
        pw_q     <= '0;
      end else begin
        unique case (state_q)
          ST_SLEEP: begin
            if (!line_f) begin
              if (pw_q == WAKE_LO_C) begin
                awake_o <= 1'b1;
                wd_q    <= '0;
                pw_q    <= '0;
                state_q <= ST_GUARD;
              end else begin
                pw_q <= pw_q + 1'b1;
              end
            end else begin
              pw_q <= '0;
            end
          end
          ST_GUARD: begin
            if (!line_f) begin
              pw_q <= '0;
            end else if (pw_q == WAKE_HI_C) begin
              pw_q    <= '0;
              state_q <= ST_IDLE;
            end else begin
              pw_q <= pw_q + 1'b1;
            end
          end
          ST_IDLE: begin
            if (!line_f) begin
              state_q  <= ST_LOW;
              pw_q     <= PW_W'(1);
              tok_q    <= TOK_W'(1);
              second_q <= 1'b0;
              if (!to_arm_q) begin
                to_arm_q <= 1'b1;
                to_q     <= '0;
              end
            end
          end
          ST_LOW: begin
            tok_q <= tok_q + 1'b1;
            if (!line_f) begin
              if (pw_q == START_MAX_C) begin
                err_q   <= 1'b1;
                state_q <= ST_ERR;
              end else begin
                pw_q <= pw_q + 1'b1;
              end
            end else if (pw_q < START_MIN_C) begin
              err_q   <= 1'b1;
              state_q <= ST_ERR;
            end else begin
              state_q <= ST_HIGH;
            end
          end
          ST_HIGH: begin
            tok_q <= tok_q + 1'b1;
            if (!line_f) begin
              if (second_q) begin
                err_q   <= 1'b1;
                state_q <= ST_ERR;
              end else begin
                second_q <= 1'b1;
                pw_q     <= PW_W'(1);
                state_q  <= ST_LOW;
              end
            end else if (tok_q >= DECIDE_C) begin
              bit_vld_q <= 1'b1;
              bit_val_q <= !second_q;
              to_arm_q  <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end
          ST_ERR: begin
            if (line_f) state_q <= ST_IDLE;
          end
          default: state_q <= ST_SLEEP;
        endcase
      end
    end
  end

  assign frame_err_o = err_q;

  swi_word_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (err_q || !awake_o),
    .bit_vld_i (bit_vld_q),
    .bit_i     (bit_val_q),
    .word_o    (word_o),
    .word_vld_o(word_vld_o)
  );
endmodule

// File: rtl/swi_token_rx_chk.sv
module swi_token_rx_chk #(
  parameter int WDOG_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic awake_o,
  input logic word_vld_o,
  input logic frame_err_o
);
  int unsigned awake_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) awake_cnt <= 0;
    else if (awake_o) awake_cnt <= awake_cnt + 1;
    else awake_cnt <= 0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !awake_o && !word_vld_o && !frame_err_o);

  p_sleep_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_o |-> !word_vld_o && !frame_err_o);

  p_wake_on_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awake_o) |-> !$past(line_i, 8));

  p_strobe_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  p_err_no_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !word_vld_o);

  p_awake_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o |-> awake_cnt < WDOG_CYC);
endmodule

bind swi_token_rx swi_token_rx_chk #(.WDOG_CYC(WDOG_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_i     (line_i),
  .awake_o    (awake_o),
  .word_vld_o (word_vld_o),
  .frame_err_o(frame_err_o)
);

// File: tb/swi_token_rx_bench.sv
module swi_token_rx_bench;
  localparam int CLK_PERIOD_NS = 50;  // 20 MHz
  localparam int BIT_CYC = 780;
  localparam int NOM_W   = 87;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_i = 1'b1;
  logic       awake_o;
  logic [7:0] word_o;
  logic       word_vld_o;
  logic       frame_err_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_words = 0;
  int n_errs = 0;
  logic [7:0] last_word = '0;

  // data byte, low pulse width in cycles
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 8'd84}, {8'hFF, 8'd87}, {8'hA5, 8'd90},
    {8'h3C, 8'd84}, {8'h81, 8'd87}, {8'h7E, 8'd90}
  };

  always #(CLK_PERIOD_NS / 2) clk_i = ~clk_i;

  swi_token_rx #(
    .CLK_MHZ   (20),
    .WAKE_HI_NS(20000),
    .TIMEOUT_NS(200000),
    .WDOG_NS   (2000000)
  ) u_swi_token_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .awake_o    (awake_o),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .frame_err_o(frame_err_o)
  );

  always @(negedge clk_i) begin
    if (word_vld_o) begin
      n_words++;
      last_word = word_o;
    end
    if (frame_err_o) n_errs++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    line_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b, input int w, input bit glitch);
    if (b) begin
      drive(1'b0, w);
      if (glitch) begin
        drive(1'b1, 300); drive(1'b0, 1); drive(1'b1, BIT_CYC - w - 301);
      end else begin
        drive(1'b1, BIT_CYC - w);
      end
    end else begin
      drive(1'b0, w);
      drive(1'b1, NOM_W);
      drive(1'b0, w);
      if (glitch) begin
        drive(1'b1, 200); drive(1'b0, 1); drive(1'b1, BIT_CYC - 2 * w - NOM_W - 201);
      end else begin
        drive(1'b1, BIT_CYC - 2 * w - NOM_W);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input int w, input bit glitch);
    for (int i = 0; i < 8; i++) send_bit(v[i], w, glitch);
  endtask

  task automatic restart_awake();
    rst_ni = 1'b0;
    drive(1'b1, 5);
    rst_ni = 1'b1;
    drive(1'b1, 20);
    drive(1'b0, 1300);
    drive(1'b1, 500);
  endtask

  task automatic expect_word(input logic [7:0] exp, input int w0, input string req);
    chk(n_words == w0 + 1, req, n_words - w0, 1);
    chk(last_word == exp, req, last_word, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0;
    int e0;
    @(negedge clk_i);
    drive(1'b1, 3);
    // R1 reset state
    chk(awake_o == 1'b0 && word_vld_o == 1'b0 && frame_err_o == 1'b0, "R1", awake_o, 0);
    rst_ni = 1'b1;
    drive(1'b1, 20);

    // R2 sleep ignores tokens and short lows
    w0 = n_words; e0 = n_errs;
    send_byte(8'h5A, NOM_W, 1'b0);
    chk(n_words == w0 && n_errs == e0, "R2", n_words - w0, 0);
    drive(1'b0, 600);
    drive(1'b1, 50);
    chk(awake_o == 1'b0, "R2", awake_o, 0);

    // R3 wake on long low
    drive(1'b0, 1300);
    drive(1'b1, 10);
    chk(awake_o == 1'b1, "R3", awake_o, 1);

    // R4 low inside guard is not decoded
    drive(1'b1, 90);
    drive(1'b0, NOM_W);
    drive(1'b1, 1000);
    w0 = n_words;
    send_byte(8'hB2, NOM_W, 1'b0);
    expect_word(8'hB2, w0, "R4");

    // R5 R6 vector table, session 1
    for (int i = 0; i < 3; i++) begin
      w0 = n_words;
      send_byte(VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);
      expect_word(VEC[i][15:8], w0, "R5_R6");
    end

    // R5 R6 vector table, session 2; R7 glitches
    restart_awake();
    for (int i = 3; i < 6; i++) begin
      w0 = n_words;
      send_byte(VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);
      expect_word(VEC[i][15:8], w0, "R5_R6");
    end
    w0 = n_words;
    send_byte(8'hD4, NOM_W, 1'b1);
    expect_word(8'hD4, w0, "R7");

    // R8 framing errors
    restart_awake();
    w0 = n_words; e0 = n_errs;
    send_bit(1'b1, NOM_W, 1'b0); send_bit(1'b0, NOM_W, 1'b0); send_bit(1'b1, NOM_W, 1'b0);
    drive(1'b0, 200);
    drive(1'b1, 600);
    chk(n_errs == e0 + 1, "R8 long low", n_errs - e0, 1);
    send_byte(8'hC3, NOM_W, 1'b0);
    expect_word(8'hC3, w0, "R8 discard");

    w0 = n_words; e0 = n_errs;
    send_bit(1'b0, NOM_W, 1'b0); send_bit(1'b1, NOM_W, 1'b0);
    drive(1'b0, 40);
    drive(1'b1, 700);
    chk(n_errs == e0 + 1, "R8 short low", n_errs - e0, 1);
    send_byte(8'h96, NOM_W, 1'b0);
    expect_word(8'h96, w0, "R8 discard");

    w0 = n_words; e0 = n_errs;
    for (int i = 0; i < 5; i++) send_bit(1'b1, NOM_W, 1'b0);
    drive(1'b0, NOM_W); drive(1'b1, NOM_W);
    drive(1'b0, NOM_W); drive(1'b1, NOM_W);
    drive(1'b0, NOM_W); drive(1'b1, 600);
    chk(n_errs == e0 + 1, "R8 third low", n_errs - e0, 1);
    send_byte(8'h3C, NOM_W, 1'b0);
    expect_word(8'h3C, w0, "R8 discard");

    // R9 no timeout without a pending token
    drive(1'b1, 5000);
    chk(awake_o == 1'b1, "R9 idle", awake_o, 1);

    // R9 timeout after an invalid token
    restart_awake();
    drive(1'b0, 200);
    drive(1'b1, 3600);
    chk(awake_o == 1'b1, "R9 before", awake_o, 1);
    drive(1'b1, 400);
    chk(awake_o == 1'b0, "R9 after", awake_o, 0);

    // R10 watchdog
    restart_awake();
    drive(1'b1, 39000);
    chk(awake_o == 1'b1, "R10 before", awake_o, 1);
    drive(1'b1, 800);
    chk(awake_o == 1'b0, "R10 after", awake_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule